// File: doc/BRIEF.md
# Wait-Stated Asynchronous Host Bus Slave

This block connects a host processor to an on-chip register file. The host bus is asynchronous and works like an SRAM: it has a 10-bit address, a data bus that is 16 bits wide or runs in a narrow 8-bit mode, and active-low select, write and read strobes. An internal clock oversamples the strobes through a synchronizer. Once an access is seen, the block raises an active-high `wait_o`. It holds `wait_o` high while it writes the register or fetches read data, and then releases it so the host can finish the cycle.

Every access has a wait phase of bounded length. The phase is four clocks long, and an internal busy input can stretch it to at most seven. When the host releases the strobes, the block enforces a two-clock inactive gap before it accepts another access. A strobe that returns too early is delayed, not dropped. In narrow mode, address bit 0 picks which byte of a 16-bit register is read or written.

The read data bus is split into a value and a per-byte-lane output enable, so that a pad ring can build the tristate from them. A disabled lane is the high-impedance state.

Top module: `host_bus_slave`

## Requirements
- R1: During reset `wait_o` is low, `data_oe_o` is 2'b00 (bus high impedance) and `reg_we_o` is low.
- R2: When select and a strobe fall together between clock edges, `wait_o` rises after the third rising edge that follows. The falling strobe passes two synchronizer flops before the access starts.
- R3: With `busy_i` low, `wait_o` stays high for exactly 4 clocks. With `busy_i` high, it stays high until the first clock from the fourth onward at which `busy_i` is low, and never for more than 7 clocks.
- R4: In 16-bit mode a read drives `data_o` with register `addr_i[9:1]` and sets `data_oe_o` = 2'b11, starting from the second wait clock. `data_o` is stable while `wait_o` falls. The enable is held until the synchronized strobe release is seen, then returns to 2'b00.
- R5: A write gives exactly one `reg_we_o` pulse, in the second wait clock. `reg_addr_o` = `addr_i[9:1]` and `reg_wdata_o` carry the values present at the start of the access.
- R6: In 8-bit mode (`wide_i` = 0) a read drives only lane 0 (`data_oe_o` = 2'b01). `data_o[7:0]` is the low byte of the register when `addr_i[0]` = 0 and the high byte when it is 1. `data_o[15:8]` = 0.
- R7: In 8-bit mode a write sets `reg_wstrb_o` = 2'b01 when `addr_i[0]` = 0 and 2'b10 when it is 1. `reg_wdata_o` carries `data_i[7:0]` in both bytes.
- R8: In 16-bit mode a write sets `reg_wstrb_o` = 2'b11, and `addr_i[0]` has no effect on `reg_addr_o`.
- R9: After the synchronized release, the block spends two clocks in a gap. A strobe that falls again one clock after release is not lost: its `wait_o` rises after the fourth rising edge instead of the third.
- R10: While select is high, write and read strobes are ignored: no wait and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 16-bit data bus, 0: 8-bit data bus |
| addr_i | input | 10 | Host byte address |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| re_ni | input | 1 | Read strobe, active low |
| data_i | input | 16 | Host write data |
| data_o | output | 16 | Read data toward the pads |
| data_oe_o | output | 2 | Per-byte-lane output enable |
| wait_o | output | 1 | Wait, active high |
| busy_i | input | 1 | Register side needs more time |
| reg_addr_o | output | 9 | Register index |
| reg_wdata_o | output | 16 | Register write data |
| reg_wstrb_o | output | 2 | Register byte write enables |
| reg_we_o | output | 1 | Register write pulse |
| reg_rdata_i | input | 16 | Register read data |

## Verification
Suppose the internal sequencer state is corrupted. A wait count that is off changes the length of `wait_o` within the same access, so it shows in at most seven clocks. A wrong gap count moves the rise of the next `wait_o` by a clock. A captured address or byte select that goes wrong shows up as a wrong lane enable, strobe or byte on the port in the second wait clock of that access. A missed release keeps `data_oe_o` driven into the gap, where a clock-by-clock comparison against a behavioural reference catches it at once.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HOLD,
    ST_GAP
  } hb_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  // reset to inactive level of active-low strobes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int WAIT_MIN = 4,
  parameter int WAIT_MAX = 7,
  parameter int GAP_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  input  logic rd_req_i,
  input  logic busy_i,
  output logic start_o,
  output logic first_o,
  output logic release_o,
  output logic is_wr_o,
  output logic wait_o
);
  localparam int CNT_W = $clog2(WAIT_MAX + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  hb_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             is_wr_q;
  logic             any_req, done_wait;

  assign any_req   = wr_req_i | rd_req_i;
  assign done_wait = (cnt_q >= CNT_W'(WAIT_MIN - 1) && !busy_i) ||
                     (cnt_q == CNT_W'(WAIT_MAX - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE: if (any_req) begin
        state_d = ST_WAIT;
        cnt_d   = '0;
      end
      ST_WAIT: if (done_wait) state_d = ST_HOLD;
               else cnt_d = cnt_q + 1'b1;
      ST_HOLD: if (!any_req) begin
        state_d = ST_GAP;
        gap_d   = GAP_W'(1);  // release cycle counts as first gap clock
      end
      ST_GAP: if (gap_q >= GAP_W'(GAP_CYC - 1)) state_d = ST_IDLE;
              else gap_d = gap_q + 1'b1;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      if (start_o) is_wr_q <= wr_req_i;
    end
  end

  assign start_o   = (state_q == ST_IDLE) && any_req;
  assign first_o   = (state_q == ST_WAIT) && (cnt_q == '0);
  assign release_o = (state_q == ST_HOLD) && !any_req;
  assign is_wr_o   = is_wr_q;
  assign wait_o    = (state_q == ST_WAIT);
endmodule

// File: rtl/hb_datapath.sv
module hb_datapath #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  first_i,
  input  logic                  release_i,
  input  logic                  is_wr_i,
  input  logic                  wide_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     data_i,
  input  logic [DATA_W-1:0]     reg_rdata_i,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] reg_addr_o,
  output logic [DATA_W-1:0]     reg_wdata_o,
  output logic [DATA_W/8-1:0]   reg_wstrb_o,
  output logic                  reg_we_o,
  output logic [DATA_W-1:0]     data_o,
  output logic [DATA_W/8-1:0]   data_oe_o
);
  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);

  logic [ADDR_W-1:0] addr_q;
  logic              wide_q;
  logic [DATA_W-1:0] wdata_q, dout_q, dout_d;
  logic [LANES-1:0]  wstrb_q, oe_q, strb_narrow;
  logic              we_q;
  logic [7:0]        rd_byte;
  logic [SEL_W-1:0]  sel_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign strb_narrow[l] = (addr_i[SEL_W-1:0] == SEL_W'(l));
  end

  assign sel_q = addr_q[SEL_W-1:0];

  always_comb begin
    rd_byte = '0;
    for (int l = 0; l < LANES; l++)
      if (sel_q == SEL_W'(l)) rd_byte = reg_rdata_i[l*8 +: 8];
    dout_d = wide_q ? reg_rdata_i : DATA_W'(rd_byte);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wide_q  <= 1'b1;
      wdata_q <= '0;
      wstrb_q <= '0;
      we_q    <= 1'b0;
      dout_q  <= '0;
      oe_q    <= '0;
    end else begin
      if (start_i) begin
        addr_q  <= addr_i;
        wide_q  <= wide_i;
        wdata_q <= wide_i ? data_i : {LANES{data_i[7:0]}};
        wstrb_q <= wide_i ? '1 : strb_narrow;
      end
      we_q <= first_i && is_wr_i;
      if (first_i && !is_wr_i) begin
        dout_q <= dout_d;
        oe_q   <= wide_q ? '1 : LANES'(1);
      end else if (release_i) begin
        oe_q <= '0;
      end
    end
  end

  assign reg_addr_o  = addr_q[ADDR_W-1:SEL_W];
  assign reg_wdata_o = wdata_q;
  assign reg_wstrb_o = wstrb_q;
  assign reg_we_o    = we_q;
  assign data_o      = dout_q;
  assign data_oe_o   = oe_q;
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int WAIT_MIN    = 4,
  parameter int WAIT_MAX    = 7,
  parameter int GAP_CYC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wide_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  cs_ni,
  input  logic                  we_ni,
  input  logic                  re_ni,
  input  logic [DATA_W-1:0]     data_i,
  output logic [DATA_W-1:0]     data_o,
  output logic [DATA_W/8-1:0]   data_oe_o,
  output logic                  wait_o,
  input  logic                  busy_i,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] reg_addr_o,
  output logic [DATA_W-1:0]     reg_wdata_o,
  output logic [DATA_W/8-1:0]   reg_wstrb_o,
  output logic                  reg_we_o,
  input  logic [DATA_W-1:0]     reg_rdata_i
);
  logic [2:0] strb_s;
  logic       cs_s, we_s, re_s;
  logic       wr_req, rd_req;
  logic       start, first, release_acc, is_wr;

  hb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, we_ni, re_ni}),
    .q_o    (strb_s)
  );

  assign {cs_s, we_s, re_s} = strb_s;
  assign wr_req = !cs_s && !we_s;
  assign rd_req = !cs_s && !re_s && we_s;  // write wins when both low

  hb_ctrl #(
    .WAIT_MIN (WAIT_MIN),
    .WAIT_MAX (WAIT_MAX),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (wr_req),
    .rd_req_i  (rd_req),
    .busy_i    (busy_i),
    .start_o   (start),
    .first_o   (first),
    .release_o (release_acc),
    .is_wr_o   (is_wr),
    .wait_o    (wait_o)
  );

  hb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .first_i     (first),
    .release_i   (release_acc),
    .is_wr_i     (is_wr),
    .wide_i      (wide_i),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_wstrb_o (reg_wstrb_o),
    .reg_we_o    (reg_we_o),
    .data_o      (data_o),
    .data_oe_o   (data_oe_o)
  );
endmodule

// File: rtl/host_bus_slave_chk.sv
module host_bus_slave_chk #(
  parameter int WAIT_MIN = 4,
  parameter int WAIT_MAX = 7,
  parameter int DATA_W   = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wait_o,
  input logic                reg_we_o,
  input logic [DATA_W-1:0]   data_o,
  input logic [DATA_W/8-1:0] data_oe_o
);
  localparam int RUN_W = $clog2(WAIT_MAX + 2);
  logic [RUN_W-1:0] run_q;

  // consecutive high clocks of wait seen before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (wait_o) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!wait_o && data_oe_o == '0 && !reg_we_o);
    end
  end

  assert_wait_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> run_q < RUN_W'(WAIT_MAX));

  assert_wait_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_o) |-> run_q >= RUN_W'(WAIT_MIN));

  assert_rd_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wait_o) && data_oe_o != '0) |-> $stable(data_o));

  assert_we_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_we_in_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (wait_o && data_oe_o == '0));

  assert_lane_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o == '0) || (data_oe_o == '1) || (data_oe_o == (DATA_W/8)'(1)));
endmodule

bind host_bus_slave host_bus_slave_chk #(
  .WAIT_MIN (WAIT_MIN),
  .WAIT_MAX (WAIT_MAX),
  .DATA_W   (DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wait_o    (wait_o),
  .reg_we_o  (reg_we_o),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/host_bus_slave_bench.sv
module host_bus_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wide = 1'b1;
  logic [9:0]  addr = '0;
  logic        cs_n = 1'b1, we_n = 1'b1, re_n = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  oe;
  logic        wt;
  logic        busy = 1'b0;
  logic [8:0]  raddr;
  logic [15:0] rwdata;
  logic [1:0]  rwstrb;
  logic        rwe;
  logic [15:0] rrdata;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  host_bus_slave u_host_bus_slave (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .addr_i(addr),
    .cs_ni(cs_n), .we_ni(we_n), .re_ni(re_n), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .wait_o(wt), .busy_i(busy),
    .reg_addr_o(raddr), .reg_wdata_o(rwdata), .reg_wstrb_o(rwstrb),
    .reg_we_o(rwe), .reg_rdata_i(rrdata)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 257) ^ 16'h5a3c;
  endfunction

  // register file seen by the design
  logic [15:0] regs [512];
  initial for (int i = 0; i < 512; i++) regs[i] = init_val(i);
  assign rrdata = regs[raddr];
  always @(posedge clk) if (rwe) begin
    if (rwstrb[0]) regs[raddr][7:0]  <= rwdata[7:0];
    if (rwstrb[1]) regs[raddr][15:8] <= rwdata[15:8];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  logic [15:0] m_regs [512];
  initial for (int i = 0; i < 512; i++) m_regs[i] = init_val(i);
  int          m_phase = 0, m_k = 0, m_g = 0;
  bit          m_wr = 0, m_w16 = 1;
  logic [9:0]  m_a = '0;
  logic [15:0] m_d = '0;
  bit          h_cs[2] = '{1, 1}, h_we[2] = '{1, 1}, h_re[2] = '{1, 1};
  bit          x_wait = 0, x_we = 0;
  logic [1:0]  x_oe = '0, x_strb = '0;
  logic [15:0] x_dout = '0, x_wdata = '0;
  logic [8:0]  x_addr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_k = 0; m_g = 0;
      h_cs = '{1, 1}; h_we = '{1, 1}; h_re = '{1, 1};
      x_wait = 0; x_we = 0; x_oe = '0;
    end else begin
      bit act_w, act_any;
      act_w   = !h_cs[1] && !h_we[1];
      act_any = !h_cs[1] && (!h_we[1] || !h_re[1]);
      x_we = 0;
      if (m_phase == 0) begin
        if (act_any) begin
          m_phase = 1; m_k = 0; m_wr = act_w; m_a = addr; m_d = din; m_w16 = wide;
        end
      end else if (m_phase == 1) begin
        if (m_k == 0) begin
          if (m_wr) begin
            x_we = 1; x_addr = m_a[9:1];
            x_strb = m_w16 ? 2'b11 : (m_a[0] ? 2'b10 : 2'b01);
            x_wdata = m_w16 ? m_d : {m_d[7:0], m_d[7:0]};
            if (x_strb[0]) m_regs[x_addr][7:0]  = x_wdata[7:0];
            if (x_strb[1]) m_regs[x_addr][15:8] = x_wdata[15:8];
          end else begin
            x_oe = m_w16 ? 2'b11 : 2'b01;
            x_dout = m_w16 ? m_regs[m_a[9:1]] :
                     {8'h00, (m_a[0] ? m_regs[m_a[9:1]][15:8] : m_regs[m_a[9:1]][7:0])};
          end
        end
        if ((m_k >= 3 && !busy) || m_k == 6) m_phase = 2;
        else m_k++;
      end else if (m_phase == 2) begin
        if (!act_any) begin m_phase = 3; m_g = 1; x_oe = '0; end
      end else begin
        if (m_g + 1 >= 2) m_phase = 0; else m_g++;
      end
      x_wait = (m_phase == 1);
      h_cs[1] = h_cs[0]; h_cs[0] = cs_n;
      h_we[1] = h_we[0]; h_we[0] = we_n;
      h_re[1] = h_re[0]; h_re[0] = re_n;
    end
  end

  // per-clock comparison and write monitor, away from the active edge
  int          we_cnt = 0;
  logic [8:0]  seen_addr;
  logic [15:0] seen_wdata;
  logic [1:0]  seen_strb;
  bit          cmp_on = 0;
  always @(negedge clk) begin
    if (rwe) begin we_cnt++; seen_addr = raddr; seen_wdata = rwdata; seen_strb = rwstrb; end
    if (cmp_on) begin
      check("R3 wait vs model", 32'(wt), 32'(x_wait));
      check("R4 oe vs model", 32'(oe), 32'(x_oe));
      if (x_oe != 0) check("R4 data vs model", 32'(dout), 32'(x_dout));
      check("R5 we vs model", 32'(rwe), 32'(x_we));
      if (x_we) begin
        check("R5 addr vs model", 32'(raddr), 32'(x_addr));
        check("R5 wdata vs model", 32'(rwdata), 32'(x_wdata));
        check("R7 strb vs model", 32'(rwstrb), 32'(x_strb));
      end
    end
  end

  task automatic access(input bit wr, input logic [9:0] a, input logic [15:0] d,
                        input int blen, input bit b2b,
                        output logic [15:0] rdv, output logic [1:0] oev,
                        output int rdly, output int wlen);
    if (b2b) @(negedge clk); else repeat (4) @(negedge clk);
    addr = a; din = d; cs_n = 0; we_n = !wr; re_n = wr; busy = (blen > 0);
    rdly = 0; wlen = 0;
    while (!wt && rdly < 20) begin @(negedge clk); rdly++; end
    while (wt && wlen < 20) begin
      wlen++; busy = (wlen < blen);
      @(negedge clk);
    end
    rdv = dout; oev = oe;
    cs_n = 1; we_n = 1; re_n = 1; busy = 0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rv;
    logic [1:0]  ov;
    int rd, wl;
    #1 rst_n = 0;
    repeat (3) begin
      @(negedge clk);
      check("R1 wait in reset", 32'(wt), 0);
      check("R1 oe in reset", 32'(oe), 0);
      check("R1 we in reset", 32'(rwe), 0);
    end
    rst_n = 1; cmp_on = 1;

    // 16-bit write, odd address bit ignored
    we_cnt = 0;
    access(1, 10'h084, 16'hBEEF, 0, 0, rv, ov, rd, wl);
    check("R2 wait delay", 32'(rd), 3);
    check("R3 wait length idle", 32'(wl), 4);
    check("R5 one write pulse", 32'(we_cnt), 1);
    check("R5 reg index", 32'(seen_addr), 32'h042);
    check("R5 write data", 32'(seen_wdata), 32'hBEEF);
    check("R8 strobes wide", 32'(seen_strb), 2'b11);
    access(1, 10'h0C5, 16'h1234, 0, 0, rv, ov, rd, wl);
    check("R8 bit0 ignored", 32'(seen_addr), 32'h062);

    // 16-bit reads, with busy stretching
    access(0, 10'h084, 16'h0, 0, 0, rv, ov, rd, wl);
    check("R4 read data", 32'(rv), 32'hBEEF);
    check("R4 read lanes", 32'(ov), 2'b11);
    repeat (3) @(negedge clk);
    check("R4 oe released", 32'(oe), 0);
    access(0, 10'h0C4, 16'h0, 6, 0, rv, ov, rd, wl);
    check("R3 busy stretch", 32'(wl), 6);
    check("R4 read data 2", 32'(rv), 32'h1234);
    access(0, 10'h0C4, 16'h0, 12, 0, rv, ov, rd, wl);
    check("R3 busy capped", 32'(wl), 7);

    // narrow reads
    wide = 0;
    access(0, 10'h085, 16'h0, 0, 0, rv, ov, rd, wl);
    check("R6 high byte", 32'(rv), 32'h00BE);
    check("R6 lane0 only", 32'(ov), 2'b01);
    access(0, 10'h084, 16'h0, 0, 0, rv, ov, rd, wl);
    check("R6 low byte", 32'(rv), 32'h00EF);

    // narrow writes
    access(1, 10'h101, 16'hC377, 0, 0, rv, ov, rd, wl);
    check("R7 strobe high", 32'(seen_strb), 2'b10);
    check("R7 replicated", 32'(seen_wdata), 32'h7777);
    wide = 1;
    access(0, 10'h100, 16'h0, 0, 0, rv, ov, rd, wl);
    check("R7 merged word", 32'(rv), 32'({8'h77, init_val(128)[7:0]}));
    wide = 0;
    access(1, 10'h100, 16'hAA55, 0, 0, rv, ov, rd, wl);
    check("R7 strobe low", 32'(seen_strb), 2'b01);
    check("R7 replicated low", 32'(seen_wdata), 32'h5555);

    // early reassert during gap
    wide = 1;
    access(1, 10'h010, 16'h0F0F, 0, 0, rv, ov, rd, wl);
    access(0, 10'h010, 16'h0, 0, 1, rv, ov, rd, wl);
    check("R9 delayed start", 32'(rd), 4);
    check("R9 data after gap", 32'(rv), 32'h0F0F);

    // strobes without select
    we_cnt = 0;
    repeat (4) @(negedge clk);
    we_n = 0; addr = 10'h010; din = 16'hDEAD;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R10 no wait", 32'(wt), 0);
    end
    we_n = 1;
    repeat (4) @(negedge clk);
    check("R10 no write", 32'(we_cnt), 0);
    access(0, 10'h010, 16'h0, 0, 0, rv, ov, rd, wl);
    check("R10 reg unchanged", 32'(rv), 32'h0F0F);

    repeat (6) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule